// File: doc/BRIEF.md
# Home-Node Full-Map Directory Controller

This block sits at the home node of a small shared-memory system. For each memory block it keeps one directory entry: a presence vector with one bit per processor, and an owner (dirty) bit. A processor sends a read or write request tagged with its own index and a block index. The controller looks up the entry and, when the block is held elsewhere, sends recall or invalidate messages to the caches. It collects their acknowledgements, keeps a local model of memory up to date, and answers the requester with data (for a read) or a write grant that carries data (for a write). One transaction is handled at a time. While it is in progress the request port holds `req_ready` low, so a second request to any block, including the busy one, waits at the port.

The sequencer is a seven-state machine:
- `ST_IDLE` accepts a request and moves to `ST_LOOKUP`.
- `ST_LOOKUP` reads the entry and chooses one of three paths:
  - `ST_REPLY` when no message is needed.
  - `ST_RECALL` when another processor owns the line.
  - `ST_INV_SEND` when a write must clear sharers.
- `ST_INV_SEND` sends one invalidate per cycle, lowest processor index first. After the last one it moves to `ST_INV_WAIT`.
- `ST_INV_WAIT` holds until the outstanding-acknowledge counter reaches zero, then moves to `ST_REPLY`.
- `ST_RECALL` sends a single recall to the owner and moves to `ST_RECALL_WAIT`.
- `ST_RECALL_WAIT` holds until the owner returns its data, then moves to `ST_REPLY`.
- `ST_REPLY` drives the response for one cycle, writes the new entry and returns to `ST_IDLE`.

Message kinds on `msg_kind`:
- 2'b01: recall with downgrade to shared.
- 2'b10: recall with invalidate.
- 2'b11: invalidate.

Response kinds on `rsp_kind`:
- 0: read data.
- 1: write grant.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry has an empty presence vector and a clear owner bit. Memory word b holds 16'hD000 | b. `req_ready` is high, and `msg_valid` and `rsp_valid` are low.
- R2: A read of a block with a clear owner bit sends no message. It answers with `rsp_kind` 0 and the memory word, and adds the requester to the presence vector.
- R3: A read by a processor other than the owner of a dirty block sends exactly one message, kind 2'b01, to the owner. When the owner's acknowledge returns with data, that data is written to memory and forwarded in the response. The owner bit is cleared, and both the old owner and the requester remain sharers.
- R4: A write to a block with a clear owner bit sends one invalidate (kind 2'b11) per cycle to every sharer except the requester, in ascending processor index. The grant (`rsp_kind` 1, memory word) is sent only after as many acknowledges as invalidates have been taken. With no other sharer, the grant follows at once. Afterwards only the requester is present and the owner bit is set.
- R5: A write by a processor other than the owner of a dirty block sends one message, kind 2'b10, to the owner. Memory takes the returned data and the grant carries it. The owner bit stays set, and the requester becomes the only processor present.
- R6: A read or write by the processor that already owns a dirty block sends no message. It answers at once with the memory word and leaves the entry unchanged.
- R7: `req_ready` is low from the cycle after a request is accepted through the response cycle, and is high in the cycle after the response.
- R8: The directory never records a set owner bit together with anything other than exactly one presence bit. The outstanding-acknowledge count is never decremented below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write (ownership) request, 0 = read |
| req_src | input | 2 | Requesting processor index |
| req_blk | input | 4 | Block index |
| msg_valid | output | 1 | Coherence message to a cache this cycle |
| msg_kind | output | 2 | 01 recall-share, 10 recall-invalidate, 11 invalidate |
| msg_dst | output | 2 | Destination processor |
| msg_blk | output | 4 | Block the message concerns |
| ack_valid | input | 1 | Acknowledge from a cache |
| ack_src | input | 2 | Processor sending the acknowledge |
| ack_data | input | 16 | Line data returned with a recall acknowledge |
| rsp_valid | output | 1 | Response to the requester (one cycle) |
| rsp_kind | output | 1 | 0 read data, 1 write grant |
| rsp_dst | output | 2 | Requester index |
| rsp_data | output | 16 | Line data supplied to the requester |

## Verification
The bench goes after several corner cases, each with the failure it would expose:
- A write whose requester is itself a sharer. A design that did not exclude the requester would invalidate it and wait for an acknowledge that never comes.
- A write with every other processor sharing. This checks both the ascending send order and that the grant waits for the last acknowledge; a miscounting design grants early or hangs.
- Acknowledges that arrive while invalidates are still being sent, which a design counting only in the wait state would miss.
- A request from the current owner. A design that recalled from the requester would deadlock.
- A read after a recall. This shows whether memory really took the recalled data.
- A random mix over four blocks. After a write, any stale presence bit shows up later as an extra invalidate.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;

    typedef enum logic [1:0] {
        MSG_NONE       = 2'b00,
        MSG_RECALL_SHR = 2'b01,
        MSG_RECALL_INV = 2'b10,
        MSG_INVAL      = 2'b11
    } msg_kind_t;

    typedef enum logic {
        RSP_RDATA  = 1'b0,
        RSP_WGRANT = 1'b1
    } rsp_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_LOOKUP      = 3'd1,
        ST_INV_SEND    = 3'd2,
        ST_INV_WAIT    = 3'd3,
        ST_RECALL      = 3'd4,
        ST_RECALL_WAIT = 3'd5,
        ST_REPLY       = 3'd6
    } dir_state_t;

endpackage

// File: rtl/dir_sharer_scan.sv
module dir_sharer_scan #(
    parameter int K = 4
) (
    input  logic [K-1:0]           mask,
    output logic [$clog2(K)-1:0]   first_idx,
    output logic [$clog2(K+1)-1:0] count
);
    localparam int KW = $clog2(K);
    localparam int CW = $clog2(K + 1);

    // lowest set index and population of the mask
    always_comb begin
        first_idx = '0;
        count     = '0;
        for (int i = K - 1; i >= 0; i--) begin
            if (mask[i]) first_idx = KW'(i);
        end
        for (int i = 0; i < K; i++) begin
            count = count + CW'(mask[i]);
        end
    end
endmodule

// File: rtl/dir_entry_store.sv
module dir_entry_store #(
    parameter int K       = 4,
    parameter int ENTRIES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    output logic [K-1:0]               rd_pres,
    output logic                       rd_dirty,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [K-1:0]               wr_pres,
    input  logic                       wr_dirty
);
    localparam int IW = $clog2(ENTRIES);

    logic [ENTRIES-1:0][K-1:0] pres_all;
    logic [ENTRIES-1:0]        dirty_all;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic [K-1:0] pres_e;
        logic         dirty_e;
        logic         hit;

        assign hit = wr_en && (wr_idx == IW'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pres_e  <= '0;
                dirty_e <= 1'b0;
            end else if (hit) begin
                pres_e  <= wr_pres;
                dirty_e <= wr_dirty;
            end
        end

        assign pres_all[e]  = pres_e;
        assign dirty_all[e] = dirty_e;
    end

    assign rd_pres  = pres_all[rd_idx];
    assign rd_dirty = dirty_all[rd_idx];
endmodule

// File: rtl/dir_data_store.sv
module dir_data_store #(
    parameter int             ENTRIES   = 16,
    parameter int             DW        = 16,
    parameter logic [DW-1:0]  INIT_BASE = 'hD000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    output logic [DW-1:0]              rd_data,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [DW-1:0]              wr_data
);
    localparam int IW = $clog2(ENTRIES);

    logic [ENTRIES-1:0][DW-1:0] words;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_word
        logic [DW-1:0] word_e;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_e <= INIT_BASE | DW'(e);
            end else if (wr_en && (wr_idx == IW'(e))) begin
                word_e <= wr_data;
            end
        end

        assign words[e] = word_e;
    end

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_home_pkg::*;
#(
    parameter int            K         = 4,
    parameter int            ENTRIES   = 16,
    parameter int            DW        = 16,
    parameter logic [DW-1:0] INIT_BASE = 'hD000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [$clog2(K)-1:0]       req_src,
    input  logic [$clog2(ENTRIES)-1:0] req_blk,
    output logic                       msg_valid,
    output logic [1:0]                 msg_kind,
    output logic [$clog2(K)-1:0]       msg_dst,
    output logic [$clog2(ENTRIES)-1:0] msg_blk,
    input  logic                       ack_valid,
    input  logic [$clog2(K)-1:0]       ack_src,
    input  logic [DW-1:0]              ack_data,
    output logic                       rsp_valid,
    output logic                       rsp_kind,
    output logic [$clog2(K)-1:0]       rsp_dst,
    output logic [DW-1:0]              rsp_data
);
    localparam int KW = $clog2(K);
    localparam int IW = $clog2(ENTRIES);
    localparam int CW = $clog2(K + 1);

    dir_state_t     state_q, state_d;

    // latched request and transaction context
    logic           wr_q;
    logic           selfown_q;
    logic [KW-1:0]  src_q;
    logic [KW-1:0]  own_q;
    logic [IW-1:0]  blk_q;
    logic [K-1:0]   pres_q;
    logic [K-1:0]   pend_q;
    logic [CW-1:0]  cnt_q;
    logic [DW-1:0]  data_q;

    // lookup results
    logic [K-1:0]   rd_pres;
    logic           rd_dirty;
    logic [DW-1:0]  rd_data;

    // shared scanner
    logic [K-1:0]   scan_mask;
    logic [KW-1:0]  scan_first;
    logic [CW-1:0]  scan_cnt;

    logic [K-1:0]   src_bit;
    logic [K-1:0]   first_bit;
    logic           recall_hit;
    logic           ack_count;
    logic           ent_wr_en;
    logic [K-1:0]   ent_wr_pres;
    logic           ent_wr_dirty;

    assign src_bit    = K'(1) << src_q;
    assign first_bit  = K'(1) << scan_first;
    assign scan_mask  = (state_q == ST_LOOKUP) ? (rd_pres & ~src_bit) : pend_q;
    assign recall_hit = (state_q == ST_RECALL_WAIT) && ack_valid && (ack_src == own_q);
    assign ack_count  = ack_valid && (cnt_q != '0) &&
                        ((state_q == ST_INV_SEND) || (state_q == ST_INV_WAIT));

    // entry update at reply: a write leaves only the requester, a read adds it
    assign ent_wr_en    = (state_q == ST_REPLY) && !selfown_q;
    assign ent_wr_dirty = wr_q;
    assign ent_wr_pres  = wr_q ? src_bit : (pres_q | src_bit);

    dir_entry_store #(
        .K       (K),
        .ENTRIES (ENTRIES)
    ) u_entries (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (blk_q),
        .rd_pres  (rd_pres),
        .rd_dirty (rd_dirty),
        .wr_en    (ent_wr_en),
        .wr_idx   (blk_q),
        .wr_pres  (ent_wr_pres),
        .wr_dirty (ent_wr_dirty)
    );

    dir_data_store #(
        .ENTRIES   (ENTRIES),
        .DW        (DW),
        .INIT_BASE (INIT_BASE)
    ) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (blk_q),
        .rd_data (rd_data),
        .wr_en   (recall_hit),
        .wr_idx  (blk_q),
        .wr_data (ack_data)
    );

    dir_sharer_scan #(
        .K (K)
    ) u_scan (
        .mask      (scan_mask),
        .first_idx (scan_first),
        .count     (scan_cnt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (rd_dirty) begin
                    state_d = (scan_cnt == '0) ? ST_REPLY : ST_RECALL;
                end else if (wr_q && (scan_cnt != '0)) begin
                    state_d = ST_INV_SEND;
                end else begin
                    state_d = ST_REPLY;
                end
            end
            ST_INV_SEND: begin
                if ((pend_q & ~first_bit) == '0) state_d = ST_INV_WAIT;
            end
            ST_INV_WAIT: begin
                if (cnt_q == '0) state_d = ST_REPLY;
            end
            ST_RECALL: begin
                state_d = ST_RECALL_WAIT;
            end
            ST_RECALL_WAIT: begin
                if (recall_hit) state_d = ST_REPLY;
            end
            ST_REPLY: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            selfown_q <= 1'b0;
            src_q     <= '0;
            own_q     <= '0;
            blk_q     <= '0;
            pres_q    <= '0;
            pend_q    <= '0;
            cnt_q     <= '0;
            data_q    <= '0;
        end else begin
            if ((state_q == ST_IDLE) && req_valid) begin
                wr_q  <= req_write;
                src_q <= req_src;
                blk_q <= req_blk;
            end
            if (state_q == ST_LOOKUP) begin
                data_q    <= rd_data;
                pres_q    <= rd_pres;
                own_q     <= scan_first;
                selfown_q <= rd_dirty && (scan_cnt == '0);
                if (!rd_dirty && wr_q) begin
                    pend_q <= scan_mask;
                    cnt_q  <= scan_cnt;
                end else begin
                    pend_q <= '0;
                    cnt_q  <= '0;
                end
            end
            if (state_q == ST_INV_SEND) begin
                pend_q <= pend_q & ~first_bit;
            end
            if (ack_count) begin
                cnt_q <= cnt_q - CW'(1);
            end
            if (recall_hit) begin
                data_q <= ack_data;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        msg_valid = 1'b0;
        msg_kind  = MSG_NONE;
        msg_dst   = own_q;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_INV_SEND: begin
                msg_valid = 1'b1;
                msg_kind  = MSG_INVAL;
                msg_dst   = scan_first;
            end
            ST_RECALL: begin
                msg_valid = 1'b1;
                msg_kind  = wr_q ? MSG_RECALL_INV : MSG_RECALL_SHR;
            end
            ST_REPLY: begin
                rsp_valid = 1'b1;
            end
            default: begin
            end
        endcase
    end

    assign msg_blk  = blk_q;
    assign rsp_kind = wr_q;
    assign rsp_dst  = src_q;
    assign rsp_data = data_q;

endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk
    import dir_home_pkg::*;
#(
    parameter int K  = 4,
    parameter int DW = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic                     msg_valid,
    input logic [1:0]               msg_kind,
    input logic                     ack_valid,
    input logic [$clog2(K)-1:0]     ack_src,
    input logic [DW-1:0]            ack_data,
    input logic                     rsp_valid,
    input logic                     rsp_kind,
    input logic [DW-1:0]            rsp_data,
    input dir_state_t               state,
    input logic [$clog2(K+1)-1:0]   cnt,
    input logic [$clog2(K)-1:0]     own,
    input logic                     ent_wr_en,
    input logic [K-1:0]             ent_wr_pres,
    input logic                     ent_wr_dirty
);

    assert_accept_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_reopen_after_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    assert_single_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_wr_en && ent_wr_dirty) |-> ($countones(ent_wr_pres) == 1));

    assert_no_ack_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ((state == ST_INV_SEND) || (state == ST_INV_WAIT))) |-> (cnt != '0));

    assert_grant_after_acks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind) |-> (cnt == '0));

    assert_recall_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RECALL_WAIT) && ack_valid && (ack_src == own))
            |=> (rsp_valid && (rsp_data == $past(ack_data))));

    assert_msg_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_kind != 2'b00));

endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.K(K), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .msg_valid    (msg_valid),
    .msg_kind     (msg_kind),
    .ack_valid    (ack_valid),
    .ack_src      (ack_src),
    .ack_data     (ack_data),
    .rsp_valid    (rsp_valid),
    .rsp_kind     (rsp_kind),
    .rsp_data     (rsp_data),
    .state        (state_q),
    .cnt          (cnt_q),
    .own          (own_q),
    .ent_wr_en    (ent_wr_en),
    .ent_wr_pres  (ent_wr_pres),
    .ent_wr_dirty (ent_wr_dirty)
);

// File: tb/dir_home_ctrl_test.sv
module dir_home_ctrl_test;
    localparam int K       = 4;
    localparam int ENTRIES = 16;
    localparam int DW      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_src = '0;
    logic [3:0]  req_blk = '0;
    logic        ack_valid = 1'b0;
    logic [1:0]  ack_src = '0;
    logic [15:0] ack_data = '0;
    logic        req_ready;
    logic        msg_valid;
    logic [1:0]  msg_kind;
    logic [1:0]  msg_dst;
    logic [3:0]  msg_blk;
    logic        rsp_valid;
    logic        rsp_kind;
    logic [1:0]  rsp_dst;
    logic [15:0] rsp_data;

    always #2 clk = ~clk;

    dir_home_ctrl #(.K(K), .ENTRIES(ENTRIES), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_src(req_src), .req_blk(req_blk),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst), .msg_blk(msg_blk),
        .ack_valid(ack_valid), .ack_src(ack_src), .ack_data(ack_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst), .rsp_data(rsp_data)
    );

    int vectors = 0;
    int errs    = 0;
    int seq     = 0;

    // behavioural directory model
    logic [3:0]  m_pres [ENTRIES];
    logic        m_dirty[ENTRIES];
    logic [15:0] m_mem  [ENTRIES];
    logic [15:0] m_own  [ENTRIES];

    int          aq_src[$];
    logic [15:0] aq_dat[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_req(input bit wr, input int src, input int blk);
        logic [3:0]  sbit, emask, seen, left;
        logic [1:0]  ekind;
        logic [15:0] edata;
        bit          selfown, got;
        int          nack, cyc, edst;
        string       tag;
        sbit    = 4'b0001 << src;
        selfown = m_dirty[blk] && (m_pres[blk] == sbit);
        if (selfown) begin
            emask = '0; ekind = 2'b00; edata = m_mem[blk]; tag = "R6 owner request";
        end else if (m_dirty[blk]) begin
            emask = m_pres[blk]; ekind = wr ? 2'b10 : 2'b01; edata = m_own[blk];
            tag = wr ? "R5 write recall" : "R3 read recall";
        end else if (wr) begin
            emask = m_pres[blk] & ~sbit; ekind = 2'b11; edata = m_mem[blk];
            tag = "R4 write invalidate";
        end else begin
            emask = '0; ekind = 2'b00; edata = m_mem[blk]; tag = "R2 read clean, R1 init word";
        end

        req_valid = 1'b1; req_write = wr; req_src = 2'(src); req_blk = 4'(blk);
        @(negedge clk);
        req_valid = 1'b0;
        seen = '0; nack = 0; got = 1'b0; cyc = 0;
        while (!got && cyc < 100) begin
            chk({tag, " / R7 busy stall"}, {31'd0, req_ready}, 32'd0);
            if (rsp_valid) begin
                chk({tag, " rsp_kind"}, {31'd0, rsp_kind}, {31'd0, wr});
                chk({tag, " rsp_dst"},  {30'd0, rsp_dst}, src);
                chk({tag, " rsp_data"}, {16'd0, rsp_data}, {16'd0, edata});
                chk({tag, " messages sent"}, {28'd0, seen}, {28'd0, emask});
                chk({tag, " acks before reply"}, nack, $countones(emask));
                got = 1'b1;
            end else begin
                if (aq_src.size() > 0 && (cyc % 2 == 1)) begin
                    ack_valid = 1'b1;
                    ack_src   = 2'(aq_src.pop_front());
                    ack_data  = aq_dat.pop_front();
                    nack++;
                end else begin
                    ack_valid = 1'b0;
                end
                if (msg_valid) begin
                    left = emask & ~seen;
                    edst = -1;
                    for (int i = K - 1; i >= 0; i--) if (left[i]) edst = i;
                    if (edst < 0) begin
                        chk({tag, " unexpected message"}, {28'd0, 2'b00, msg_dst}, 32'hFFFF_FFFF);
                    end else begin
                        chk({tag, " msg_kind"}, {30'd0, msg_kind}, {30'd0, ekind});
                        chk({tag, " msg_dst order"}, {30'd0, msg_dst}, edst);
                        chk({tag, " msg_blk"}, {28'd0, msg_blk}, blk);
                    end
                    seen = seen | (4'b0001 << msg_dst);
                    aq_src.push_back(int'(msg_dst));
                    aq_dat.push_back(ekind == 2'b11 ? 16'h0000 : m_own[blk]);
                end
                @(negedge clk);
                cyc++;
            end
        end
        ack_valid = 1'b0;
        if (!got) chk({tag, " response missing"}, 32'd0, 32'd1);
        aq_src.delete();
        aq_dat.delete();

        // model update
        if (!selfown) begin
            if (m_dirty[blk]) m_mem[blk] = m_own[blk];
            if (wr) begin
                seq++;
                m_pres[blk]  = sbit;
                m_dirty[blk] = 1'b1;
                m_own[blk]   = 16'h5A00 + 16'(seq);
            end else begin
                m_pres[blk]  = m_pres[blk] | sbit;
                m_dirty[blk] = 1'b0;
            end
        end
        chk("R8 model single owner",
            {31'd0, (!m_dirty[blk] || $countones(m_pres[blk]) == 1)}, 32'd1);

        @(negedge clk);
        chk({tag, " / R7 ready after reply"}, {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        int lf;
        for (int b = 0; b < ENTRIES; b++) begin
            m_pres[b] = '0; m_dirty[b] = 1'b0;
            m_mem[b] = 16'hD000 | 16'(b); m_own[b] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R1 reset msg_valid", {31'd0, msg_valid}, 32'd0);
        chk("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);

        // sharers build up, then write with requester among them
        run_req(1'b0, 0, 3);
        run_req(1'b0, 1, 3);
        run_req(1'b0, 2, 3);
        run_req(1'b1, 1, 3);      // R4 invalidates P0, P2
        run_req(1'b1, 1, 3);      // R6 owner rewrite
        run_req(1'b0, 3, 3);      // R3 recall-share from P1
        run_req(1'b0, 0, 3);      // R3 memory took recalled data
        run_req(1'b1, 2, 3);      // R4 invalidates P0, P1, P3
        run_req(1'b1, 0, 3);      // R5 recall-invalidate from P2
        run_req(1'b0, 1, 3);      // R3 recall from P0
        run_req(1'b1, 2, 5);      // R4 no sharers: immediate grant
        run_req(1'b0, 2, 5);      // R6 read by owner
        run_req(1'b0, 1, 7);
        run_req(1'b0, 3, 7);
        run_req(1'b1, 3, 7);      // R4 only P1 invalidated
        for (int p = 0; p < K; p++) run_req(1'b0, p, 9);
        run_req(1'b1, 0, 9);      // R4 three invalidates in order
        for (int b = 10; b < ENTRIES; b++) run_req(1'b0, b % K, b);  // R1 init words

        lf = 32'h1234_5678;
        for (int n = 0; n < 80; n++) begin
            lf = lf * 1103515245 + 12345;
            run_req(lf[16], int'(lf[18:17]), int'(lf[21:20]));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end
endmodule